// File: doc/BRIEF.md
# Endpoint Buffer Command Controller

This block keeps the buffer bookkeeping for the sixteen endpoints of a USB device controller. The endpoints are control OUT at index 0, control IN at index 1, and general endpoints 1 to 14 at indices 2 to 15. The processor side issues 8-bit command codes. A validate command hands a filled IN buffer to the bus. A clear command returns an emptied OUT buffer to the bus. A status command takes a side-effect-free snapshot of one endpoint. In every command the low nibble of the code is the endpoint index.

The bus side works on tokens. For each token the block answers combinationally whether the transaction is accepted, refused or stalled, and gives the data toggle to use. It is then told when an OUT packet has been stored, or when the host has acknowledged IN data. Each general endpoint is configured as IN or OUT and as single- or double-buffered. A double-buffered endpoint keeps two separate pointers: one for the processor side and one for the bus side. This lets the two sides work on opposite buffers. A halt input stalls an endpoint.

Top module: `epb_ctrl`

## Requirements
- R1: A code from 0x61 to 0x6F sets the full flag of the processor-side buffer of IN endpoint index code[3:0]. The same code aimed at an OUT endpoint changes nothing.
- R2: Code 0x70, or a code from 0x72 to 0x7F, drops the full flag of the processor-side buffer of OUT endpoint index code[3:0]. Code 0x71, and a clear aimed at an IN endpoint, change nothing.
- R3: A stored OUT packet (rx_done) on a non-halted OUT endpoint whose bus-side buffer is empty does four things: it sets that buffer's full flag, records the setup and overflow indications, and flips the toggle. If that buffer is full, the token is answered NAK and a further packet changes nothing.
- R4: On a double-buffered endpoint, each accepted validate or clear inverts the processor-side select. Each accepted bus transfer inverts the bus-side pointer. A single-buffered endpoint always uses the primary buffer and its select reads 0.
- R5: An IN token is answered ACK (data sent) when the bus-side buffer is full, and NAK otherwise. A host acknowledge (tx_acked) then empties that buffer, flips the toggle and advances the bus-side pointer. tok_resp encodes 00 ACK, 01 NAK and 10 STALL, and never shows 11.
- R6: A halted endpoint answers STALL to every token, and its packet and acknowledge events change nothing.
- R7: A code from 0xD0 to 0xDF raises stat_valid for exactly the next cycle. stat_byte then holds the endpoint's status: bit 7 halted, bit 6 secondary full, bit 5 primary full, bit 4 toggle (1 = DATA1), bit 3 overflow, bit 2 setup, bit 1 processor-side select, bit 0 zero. Reading the status changes no state.
- R8: While rst_n is low, all state and stat_byte are 0 and stat_valid is low.
- R9: Codes whose upper nibble is not 6, 7 or D change nothing and raise no status strobe.
- R10: When a clear and a stored packet reach the same full single-buffered OUT endpoint in one cycle, the packet is judged against the flags before the clear, so it is refused and the buffer ends up empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dbl_buf | input | 16 | Per-index double-buffer enable |
| cfg_dir_in | input | 14 | Direction of endpoints 1..14 (bit n-1 = endpoint n, 1 = IN) |
| ep_halt | input | 16 | Per-index stall condition |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| stat_valid | output | 1 | Status byte valid |
| stat_byte | output | 8 | Status snapshot |
| tok_valid | input | 1 | Token present |
| tok_ep | input | 4 | Token endpoint index |
| tok_is_in | input | 1 | Token is IN |
| tok_resp | output | 2 | Handshake decision |
| tok_pid | output | 1 | Data toggle for the token's endpoint |
| rx_done | input | 1 | OUT packet stored |
| rx_ep | input | 4 | Index of stored packet |
| rx_setup | input | 1 | Stored packet was a setup |
| rx_ovf | input | 1 | Stored packet overflowed |
| tx_acked | input | 1 | Host acknowledged IN data |
| tx_ep | input | 4 | Index of acknowledged data |

## Verification
The hardest state to reach is a double-buffered endpoint whose processor-side and bus-side pointers differ while both buffers are full. Only in that state does the NAK decision depend on the bus-side pointer and not on the processor-side select. The stimulus gets there by storing two packets before any clear, or by validating twice before any acknowledge. It then checks the status after each step. A second hard case is a clear and a packet arriving in the same cycle, which is driven directly after a reset.

// File: rtl/epb_pkg.sv
package epb_pkg;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned STAT_W = 8;

  localparam logic [3:0] OP_VALIDATE = 4'h6;
  localparam logic [3:0] OP_CLEAR    = 4'h7;
  localparam logic [3:0] OP_STATUS   = 4'hD;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hs_e;

  typedef struct packed {
    logic [1:0] full;
    logic       cpu_sel;
    logic       toggle;
    logic       ovf;
    logic       setup;
  } ep_state_t;

  function automatic logic [STAT_W-1:0] stat_image(input ep_state_t s, input logic halted);
    return {halted, s.full[1], s.full[0], s.toggle, s.ovf, s.setup, s.cpu_sel, 1'b0};
  endfunction
endpackage

// File: rtl/epb_cmd_decode.sv
module epb_cmd_decode
  import epb_pkg::*;
#(
  parameter int unsigned NUM_EP = 16,
  localparam int unsigned EP_W  = $clog2(NUM_EP)
) (
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [NUM_EP-1:0] dir_in,
  output logic [NUM_EP-1:0] val_hit,
  output logic [NUM_EP-1:0] clr_hit,
  output logic              stat_req,
  output logic [EP_W-1:0]   stat_idx
);
  logic [EP_W-1:0] idx;
  logic [3:0]      op;

  assign idx      = cmd_code[EP_W-1:0];
  assign op       = cmd_code[CODE_W-1:CODE_W-4];
  assign stat_idx = idx;

  always_comb begin
    val_hit  = '0;
    clr_hit  = '0;
    stat_req = 1'b0;
    if (cmd_valid) begin
      case (op)
        OP_VALIDATE: begin
          if ((idx != EP_W'(0)) && dir_in[idx]) val_hit[idx] = 1'b1;
        end
        OP_CLEAR: begin
          if ((idx != EP_W'(1)) && !dir_in[idx]) clr_hit[idx] = 1'b1;
        end
        OP_STATUS: stat_req = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/epb_ep_slot.sv
module epb_ep_slot
  import epb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dbl,
  input  logic      dir_in,
  input  logic      halt,
  input  logic      cpu_val,
  input  logic      cpu_clr,
  input  logic      rx_hit,
  input  logic      rx_setup,
  input  logic      rx_ovf,
  input  logic      tx_hit,
  output ep_state_t st,
  output logic      usb_full
);
  ep_state_t st_q, st_d;
  logic usb_sel_q, usb_sel_d;
  logic usb_idx, cpu_idx;
  logic rx_take, tx_take, cpu_take, upd_en;

  always_comb begin
    usb_idx  = dbl & usb_sel_q;
    cpu_idx  = dbl & st_q.cpu_sel;
    usb_full = st_q.full[usb_idx];
    rx_take  = rx_hit & ~dir_in & ~halt & ~usb_full;
    tx_take  = tx_hit &  dir_in & ~halt &  usb_full;
    cpu_take = cpu_val | cpu_clr;
    upd_en   = rx_take | tx_take | cpu_take;

    st_d      = st_q;
    usb_sel_d = usb_sel_q;
    // bus-side effects first, processor-side effects last
    if (rx_take) begin
      st_d.full[usb_idx] = 1'b1;
      st_d.setup         = rx_setup;
      st_d.ovf           = rx_ovf;
      st_d.toggle        = ~st_q.toggle;
      usb_sel_d          = usb_sel_q ^ dbl;
    end
    if (tx_take) begin
      st_d.full[usb_idx] = 1'b0;
      st_d.toggle        = ~st_q.toggle;
      usb_sel_d          = usb_sel_q ^ dbl;
    end
    if (cpu_take) begin
      st_d.full[cpu_idx] = cpu_val;
      st_d.cpu_sel       = st_q.cpu_sel ^ dbl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= '0;
      usb_sel_q <= 1'b0;
    end else if (upd_en) begin
      st_q      <= st_d;
      usb_sel_q <= usb_sel_d;
    end
  end

  assign st = st_q;
endmodule

// File: rtl/epb_hs_resp.sv
module epb_hs_resp
  import epb_pkg::*;
#(
  parameter int unsigned NUM_EP = 16,
  localparam int unsigned EP_W  = $clog2(NUM_EP)
) (
  input  logic              tok_valid,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              tok_is_in,
  input  logic [NUM_EP-1:0] halt,
  input  logic [NUM_EP-1:0] dir_in,
  input  logic [NUM_EP-1:0] usb_full,
  input  logic [NUM_EP-1:0] toggle,
  output logic [1:0]        tok_resp,
  output logic              tok_pid
);
  hs_e resp;

  always_comb begin
    if (!tok_valid)                   resp = HS_NAK;
    else if (halt[tok_ep])            resp = HS_STALL;
    else if (tok_is_in != dir_in[tok_ep]) resp = HS_NAK;
    else if (tok_is_in)               resp = usb_full[tok_ep] ? HS_ACK : HS_NAK;
    else                              resp = usb_full[tok_ep] ? HS_NAK : HS_ACK;
  end

  assign tok_resp = resp;
  assign tok_pid  = toggle[tok_ep];
endmodule

// File: rtl/epb_stat_img.sv
module epb_stat_img
  import epb_pkg::*;
#(
  parameter int unsigned NUM_EP = 16,
  localparam int unsigned EP_W  = $clog2(NUM_EP)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         stat_req,
  input  logic [EP_W-1:0]              stat_idx,
  input  ep_state_t [NUM_EP-1:0]       st_all,
  input  logic [NUM_EP-1:0]            halt,
  output logic                         stat_valid,
  output logic [STAT_W-1:0]            stat_byte
);
  logic [STAT_W-1:0] byte_d;

  always_comb begin
    byte_d = stat_image(st_all[stat_idx], halt[stat_idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_byte  <= '0;
    end else begin
      stat_valid <= stat_req;
      if (stat_req) stat_byte <= byte_d;
    end
  end
endmodule

// File: rtl/epb_ctrl.sv
module epb_ctrl
  import epb_pkg::*;
#(
  parameter int unsigned NUM_EP = 16,
  localparam int unsigned EP_W  = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] cfg_dbl_buf,
  input  logic [NUM_EP-3:0] cfg_dir_in,
  input  logic [NUM_EP-1:0] ep_halt,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  output logic              stat_valid,
  output logic [STAT_W-1:0] stat_byte,
  input  logic              tok_valid,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              tok_is_in,
  output logic [1:0]        tok_resp,
  output logic              tok_pid,
  input  logic              rx_done,
  input  logic [EP_W-1:0]   rx_ep,
  input  logic              rx_setup,
  input  logic              rx_ovf,
  input  logic              tx_acked,
  input  logic [EP_W-1:0]   tx_ep
);
  logic [NUM_EP-1:0]     dir_eff;
  logic [NUM_EP-1:0]     val_hit, clr_hit;
  logic [NUM_EP-1:0]     usb_full, tog_vec;
  logic                  stat_req;
  logic [EP_W-1:0]       stat_idx;
  ep_state_t [NUM_EP-1:0] st_all;

  // index 0 is control OUT, index 1 control IN
  assign dir_eff = {cfg_dir_in, 1'b1, 1'b0};

  epb_cmd_decode #(.NUM_EP(NUM_EP)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .dir_in    (dir_eff),
    .val_hit   (val_hit),
    .clr_hit   (clr_hit),
    .stat_req  (stat_req),
    .stat_idx  (stat_idx)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic rx_hit_i, tx_hit_i;
    assign rx_hit_i = rx_done  && (rx_ep == EP_W'(i));
    assign tx_hit_i = tx_acked && (tx_ep == EP_W'(i));

    epb_ep_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .dbl      (cfg_dbl_buf[i]),
      .dir_in   (dir_eff[i]),
      .halt     (ep_halt[i]),
      .cpu_val  (val_hit[i]),
      .cpu_clr  (clr_hit[i]),
      .rx_hit   (rx_hit_i),
      .rx_setup (rx_setup),
      .rx_ovf   (rx_ovf),
      .tx_hit   (tx_hit_i),
      .st       (st_all[i]),
      .usb_full (usb_full[i])
    );
    assign tog_vec[i] = st_all[i].toggle;
  end

  epb_hs_resp #(.NUM_EP(NUM_EP)) u_hs (
    .tok_valid (tok_valid),
    .tok_ep    (tok_ep),
    .tok_is_in (tok_is_in),
    .halt      (ep_halt),
    .dir_in    (dir_eff),
    .usb_full  (usb_full),
    .toggle    (tog_vec),
    .tok_resp  (tok_resp),
    .tok_pid   (tok_pid)
  );

  epb_stat_img #(.NUM_EP(NUM_EP)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_req   (stat_req),
    .stat_idx   (stat_idx),
    .st_all     (st_all),
    .halt       (ep_halt),
    .stat_valid (stat_valid),
    .stat_byte  (stat_byte)
  );
endmodule

// File: rtl/epb_ctrl_chk.sv
module epb_ctrl_chk #(
  parameter int unsigned NUM_EP = 16,
  localparam int unsigned EP_W  = $clog2(NUM_EP)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_EP-1:0] ep_halt,
  input logic              cmd_valid,
  input logic [7:0]        cmd_code,
  input logic              stat_valid,
  input logic [7:0]        stat_byte,
  input logic              tok_valid,
  input logic [EP_W-1:0]   tok_ep,
  input logic [1:0]        tok_resp
);
  // R7
  stat_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[7:4] == 4'hD) |=> stat_valid);

  // R9
  stat_only_on_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[7:4] != 4'hD) |=> !stat_valid);

  // R7
  stat_bit0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_byte[0] == 1'b0));

  // R6
  halt_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && ep_halt[tok_ep]) |-> (tok_resp == 2'b10));

  // R6
  stall_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_resp == 2'b10) |-> (tok_valid && ep_halt[tok_ep]));

  // R5
  resp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_resp != 2'b11);

  // R8
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!stat_valid && stat_byte == 8'h00);
    end
  end
endmodule

bind epb_ctrl epb_ctrl_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ep_halt    (ep_halt),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .stat_valid (stat_valid),
  .stat_byte  (stat_byte),
  .tok_valid  (tok_valid),
  .tok_ep     (tok_ep),
  .tok_resp   (tok_resp)
);

// File: tb/epb_ctrl_tb.sv
`timescale 1ns/1ps
module epb_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_dbl_buf;
  logic [13:0] cfg_dir_in;
  logic [15:0] ep_halt;
  logic        cmd_valid;
  logic [7:0]  cmd_code;
  logic        stat_valid;
  logic [7:0]  stat_byte;
  logic        tok_valid;
  logic [3:0]  tok_ep;
  logic        tok_is_in;
  logic [1:0]  tok_resp;
  logic        tok_pid;
  logic        rx_done;
  logic [3:0]  rx_ep;
  logic        rx_setup;
  logic        rx_ovf;
  logic        tx_acked;
  logic [3:0]  tx_ep;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  epb_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_dbl_buf(cfg_dbl_buf), .cfg_dir_in(cfg_dir_in),
    .ep_halt(ep_halt), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .stat_valid(stat_valid), .stat_byte(stat_byte), .tok_valid(tok_valid),
    .tok_ep(tok_ep), .tok_is_in(tok_is_in), .tok_resp(tok_resp), .tok_pid(tok_pid),
    .rx_done(rx_done), .rx_ep(rx_ep), .rx_setup(rx_setup), .rx_ovf(rx_ovf),
    .tx_acked(tx_acked), .tx_ep(tx_ep)
  );

  // vector: {req, op, a, b}; op 0 cmd, 1 packet (b[0] setup, b[1] ovf),
  // 2 host ack, 3 token (b[7] IN, b[1:0] expected), 4 status (b expected)
  localparam int NVEC = 59;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h84_D0_00, // R8 reset image
    24'h33_00_00, // R3 empty OUT accepts
    24'h31_00_01, // R3 setup packet
    24'h34_D0_34, // R3
    24'h33_00_01, // R3 full OUT NAKs
    24'h31_00_00, // R3 refused packet
    24'h74_D0_34, // R7 repeated read unchanged
    24'h20_70_00, // R2 clear control OUT
    24'h24_D0_14, // R2
    24'h23_00_00, // R2 accepts again
    24'h20_71_00, // R2 illegal clear code
    24'h24_D1_00, // R2
    24'h24_D0_14, // R2
    24'h10_61_00, // R1 validate control IN
    24'h14_D1_20, // R1
    24'h53_01_80, // R5 data sent
    24'h52_01_00, // R5 host ack
    24'h54_D1_10, // R5
    24'h53_01_81, // R5 empty IN NAKs
    24'h41_02_00, // R4 dbl OUT first packet
    24'h44_D2_30, // R4
    24'h43_02_00, // R4 second buffer free
    24'h41_02_02, // R4 second packet with overflow
    24'h44_D2_68, // R4
    24'h43_02_01, // R4 both full
    24'h40_72_00, // R4 clear primary
    24'h44_D2_4A, // R4
    24'h43_02_00, // R4
    24'h40_72_00, // R4 clear secondary
    24'h44_D2_08, // R4
    24'h40_63_00, // R4 dbl IN validate
    24'h44_D3_22, // R4
    24'h40_63_00, // R4 validate other
    24'h44_D3_60, // R4
    24'h53_03_80, // R5
    24'h52_03_00, // R5
    24'h54_D3_50, // R5
    24'h52_03_00, // R5
    24'h54_D3_00, // R5
    24'h53_03_81, // R5
    24'h40_64_00, // R4 single IN
    24'h44_D4_20, // R4
    24'h40_64_00, // R4 select stays 0
    24'h44_D4_20, // R4
    24'h53_04_80, // R5
    24'h63_05_02, // R6 halted OUT stalls
    24'h64_D5_80, // R6
    24'h61_05_00, // R6 packet ignored
    24'h64_D5_80, // R6
    24'h10_62_00, // R1 validate on OUT ignored
    24'h14_D2_08, // R1
    24'h20_74_00, // R2 clear on IN ignored
    24'h24_D4_20, // R2
    24'h90_60_00, // R9
    24'h90_55_00, // R9
    24'h90_E4_00, // R9
    24'h94_D4_20, // R9
    24'h94_D0_14, // R9
    24'h94_D1_10  // R9
  };

  task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp, input string what);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] code);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_rx(input logic [3:0] ep, input logic su, input logic ov);
    @(negedge clk);
    rx_done = 1'b1; rx_ep = ep; rx_setup = su; rx_ovf = ov;
    @(negedge clk);
    rx_done = 1'b0; rx_setup = 1'b0; rx_ovf = 1'b0;
  endtask

  task automatic do_ack(input logic [3:0] ep);
    @(negedge clk);
    tx_acked = 1'b1; tx_ep = ep;
    @(negedge clk);
    tx_acked = 1'b0;
  endtask

  task automatic do_tok(input int req, input logic [3:0] ep, input logic is_in, input logic [1:0] exp);
    @(negedge clk);
    tok_valid = 1'b1; tok_ep = ep; tok_is_in = is_in;
    #1;
    check(req, {6'd0, tok_resp}, {6'd0, exp}, "handshake");
    tok_valid = 1'b0;
  endtask

  task automatic do_stat(input int req, input logic [7:0] code, input logic [7:0] exp);
    do_cmd(code);
    check(req, {7'd0, stat_valid}, 8'd1, "status strobe");
    check(req, stat_byte, exp, "status byte");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_dbl_buf = 16'h000C;  // indices 2 and 3 double-buffered
    cfg_dir_in  = 14'h0006;  // endpoints 2 and 3 IN
    ep_halt     = 16'h0020;  // index 5 halted
    cmd_valid = 1'b0; cmd_code = 8'h00;
    tok_valid = 1'b0; tok_ep = 4'h0; tok_is_in = 1'b0;
    rx_done = 1'b0; rx_ep = 4'h0; rx_setup = 1'b0; rx_ovf = 1'b0;
    tx_acked = 1'b0; tx_ep = 4'h0;
    repeat (3) @(negedge clk);
    // R8 outputs during reset
    check(8, {7'd0, stat_valid}, 8'd0, "reset strobe");
    check(8, stat_byte, 8'h00, "reset byte");
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] req, op;
      logic [7:0] a, b;
      {req, op, a, b} = VEC[i];
      case (op)
        4'd0: begin
          do_cmd(a);
          check(req, {7'd0, stat_valid}, 8'd0, "no strobe after non-status code");
        end
        4'd1: do_rx(a[3:0], b[0], b[1]);
        4'd2: do_ack(a[3:0]);
        4'd3: do_tok(req, a[3:0], b[7], b[1:0]);
        default: do_stat(req, a, b);
      endcase
    end

    // R7 strobe lasts one cycle
    @(negedge clk);
    check(7, {7'd0, stat_valid}, 8'd0, "strobe single cycle");
    // R5 toggle output for control IN after one transfer
    @(negedge clk);
    tok_valid = 1'b1; tok_ep = 4'h1; tok_is_in = 1'b1;
    #1;
    check(5, {7'd0, tok_pid}, 8'd1, "data toggle");
    tok_valid = 1'b0;

    // R8 reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(8, stat_byte, 8'h00, "byte in reset");
    do_tok(8, 4'h4, 1'b1, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
    do_stat(8, 8'hD4, 8'h00);

    // R10 clear and packet in the same cycle on a full buffer
    do_rx(4'h0, 1'b0, 1'b0);
    do_stat(10, 8'hD0, 8'h30);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 8'h70;
    rx_done = 1'b1; rx_ep = 4'h0; rx_setup = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; rx_done = 1'b0; rx_setup = 1'b0;
    do_stat(10, 8'hD0, 8'h10);
    do_tok(10, 4'h0, 1'b0, 2'b00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule